// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block hands the pins of an external memory interface to an outside master on request. The outside master pulls an active-low hold request. The block brings that pin into the interface timing clock domain and tells the internal access sequencer to start nothing new. It waits for any external access already under way to end, and then turns off the output drivers of the address, data and control groups. Only after that does it pull its active-low hold acknowledge.

When the outside master lets the request go high again, the block first lets the acknowledge go high. On the next cycle it turns the drivers back on, and then it lets the sequencer go. If the request is withdrawn before the acknowledge was ever given, the block goes back to normal operation and never pulses the acknowledge.

All cycle bounds below are counted in rising edges of the timing clock after the request pin changes. They hold for the default two-stage synchronizer and include its latency.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While reset is asserted, and right after it, the acknowledge is high, the stall is low and every bit of `bus_oe_o` is 1 (bit 0 address, bit 1 data, bit 2 control).
- R2: When the request falls with no access busy, all `bus_oe_o` bits are 0 after the third rising edge (limit 4).
- R3: The acknowledge goes low after the fourth rising edge (limit 5). It does so only when `bus_oe_o` was already all 0 on the cycle before.
- R4: While an access is busy, the drivers stay on. Once busy falls, the bus floats after the next edge and the acknowledge follows one edge later.
- R5: The stall is high from the second edge after the request falls, and it stays high whenever any driver is off.
- R6: When the request rises, the acknowledge returns high after the third rising edge (limit 3).
- R7: The drivers come back on after the fourth rising edge (limit 4). The acknowledge was high on the cycle before, and the stall then drops.
- R8: A request withdrawn before the acknowledge is given, either during the drain or after a one-cycle pulse, returns the block to driven and unstalled. The acknowledge never goes low.
- R9: The acknowledge is never low while any `bus_oe_o` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_req_ni | input | 1 | Hold request from the outside master, active low, asynchronous |
| acc_busy_i | input | 1 | Sequencer has an external access in progress |
| hold_ack_no | output | 1 | Hold acknowledge, active low |
| acc_stall_o | output | 1 | Tells the sequencer to start no new access |
| bus_oe_o | output | 3 | Per-group driver enables: bit 0 address, bit 1 data, bit 2 control |

## Verification
The bench goes after the cycle on which each bound is met. A design that skips or adds a synchronizer stage would float the bus or move the acknowledge one edge off.

It holds busy high through a request to catch a design that floats the bus under a live access. It withdraws the request during the drain and after a one-cycle pulse, where a faulty design would flash the acknowledge. During release it watches for a design that drives the bus while the acknowledge is still low, which would leave two masters on the pins.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

  typedef enum logic [2:0] {
    HS_IDLE    = 3'd0,
    HS_DRAIN   = 3'd1,
    HS_FLOAT   = 3'd2,
    HS_GRANT   = 3'd3,
    HS_RELEASE = 3'd4
  } hold_state_e;

  // Bit positions of the driver groups in the enable vector
  localparam int unsigned GRP_ADDR = 0;
  localparam int unsigned GRP_DATA = 1;
  localparam int unsigned GRP_CTRL = 2;
  localparam int unsigned GRP_NUM  = 3;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic req_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  // Reset value 1: the pin is active low, so this is the idle level.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= pin_ni;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign req_o = ~chain_q[LAST];

endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_arb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        busy_i,
  output hold_state_e state_o
);

  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: begin
        if (req_i) state_d = busy_i ? HS_DRAIN : HS_FLOAT;
      end
      HS_DRAIN: begin
        if (!req_i)      state_d = HS_IDLE;
        else if (!busy_i) state_d = HS_FLOAT;
      end
      HS_FLOAT: begin
        state_d = req_i ? HS_GRANT : HS_IDLE;
      end
      HS_GRANT: begin
        if (!req_i) state_d = HS_RELEASE;
      end
      HS_RELEASE: begin
        state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/hold_drive.sv
module hold_drive
  import hold_arb_pkg::*;
#(
  parameter int unsigned N_GRP = GRP_NUM
) (
  input  hold_state_e      state_i,
  input  logic             req_i,
  output logic [N_GRP-1:0] oe_o,
  output logic             ack_no,
  output logic             stall_o
);

  logic drive_on;

  // Drivers stay on only while this side still owns the pins.
  assign drive_on = (state_i == HS_IDLE) || (state_i == HS_DRAIN);

  genvar g;
  generate
    for (g = 0; g < N_GRP; g++) begin : g_grp
      assign oe_o[g] = drive_on;
    end
  endgenerate

  assign ack_no  = (state_i != HS_GRANT);
  assign stall_o = req_i || (state_i != HS_IDLE);

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import hold_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_GRP       = GRP_NUM
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_req_ni,
  input  logic             acc_busy_i,
  output logic             hold_ack_no,
  output logic             acc_stall_o,
  output logic [N_GRP-1:0] bus_oe_o
);

  logic        req_s;
  hold_state_e state;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (hold_req_ni),
    .req_o  (req_s)
  );

  hold_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_s),
    .busy_i  (acc_busy_i),
    .state_o (state)
  );

  hold_drive #(.N_GRP(N_GRP)) u_drive (
    .state_i (state),
    .req_i   (req_s),
    .oe_o    (bus_oe_o),
    .ack_no  (hold_ack_no),
    .stall_o (acc_stall_o)
  );

endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk #(
  parameter int unsigned N_GRP = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_busy_i,
  input logic             hold_ack_no,
  input logic             acc_stall_o,
  input logic [N_GRP-1:0] bus_oe_o
);

  localparam logic [N_GRP-1:0] ALL_ON = '1;

  AST_ACK_ONLY_FLOATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ack_no |-> (bus_oe_o == '0)); // R9

  AST_ACK_AFTER_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_ack_no) |-> ($past(bus_oe_o) == '0)); // R3

  AST_REDRIVE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o[0]) |-> $past(hold_ack_no)); // R7

  AST_BUSY_KEEPS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_oe_o == ALL_ON) && acc_busy_i) |=> (bus_oe_o == ALL_ON)); // R4

  AST_STALL_WHEN_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o != ALL_ON) |-> acc_stall_o); // R5

endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk #(.N_GRP(N_GRP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_busy_i  (acc_busy_i),
  .hold_ack_no (hold_ack_no),
  .acc_stall_o (acc_stall_o),
  .bus_oe_o    (bus_oe_o)
);

// File: tb/sim_bus_hold_arbiter.sv
`timescale 1ns/1ps
module sim_bus_hold_arbiter;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       hold_req_ni;
  logic       acc_busy_i;
  logic       hold_ack_no;
  logic       acc_stall_o;
  logic [2:0] bus_oe_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;
  int overlap_cnt = 0;
  int ack_low_cnt = 0;

  always #4 clk_i = ~clk_i;

  bus_hold_arbiter u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_req_ni (hold_req_ni),
    .acc_busy_i  (acc_busy_i),
    .hold_ack_no (hold_ack_no),
    .acc_stall_o (acc_stall_o),
    .bus_oe_o    (bus_oe_o)
  );

  // Packed as {req_n, busy, exp_ack_n, exp_stall, exp_oe[2:0]}.
  // Each step drives the inputs, then checks the outputs after the next edge.
  localparam int NV = 20;
  localparam logic [6:0] VEC [NV] = '{
    7'b0_0_1_0_111, // R2 edge1
    7'b0_0_1_1_111, // R5 edge2 stall
    7'b0_0_1_1_000, // R2 edge3 floated
    7'b0_0_0_1_000, // R3 edge4 ack
    7'b0_0_0_1_000, // R3 held
    7'b1_0_0_1_000, // R6 rise edge1
    7'b1_0_0_1_000, // R6 edge2
    7'b1_0_1_1_000, // R6 edge3 ack high
    7'b1_0_1_0_111, // R7 edge4 redriven
    7'b1_0_1_0_111, // R1 idle
    7'b0_1_1_0_111, // R4 edge1
    7'b0_1_1_1_111, // R4 edge2
    7'b0_1_1_1_111, // R4 drain
    7'b0_1_1_1_111, // R4 drain held
    7'b0_0_1_1_000, // R4 busy fell -> float
    7'b0_0_0_1_000, // R4 ack
    7'b1_0_0_1_000, // R6
    7'b1_0_0_1_000, // R6
    7'b1_0_1_1_000, // R6 ack high
    7'b1_0_1_0_111  // R7 redriven
  };

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ack_n,stall,oe} actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {hold_ack_no, acc_stall_o, bus_oe_o};
  endfunction

  // R9 monitor: ack low must never meet a driven group.
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (!hold_ack_no && bus_oe_o != 3'b000) overlap_cnt++;
      if (!hold_ack_no) ack_low_cnt++;
    end
  end

  task automatic step(input logic req_n, input logic busy);
    hold_req_ni = req_n;
    acc_busy_i  = busy;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    rst_ni = 1'b0; hold_req_ni = 1'b1; acc_busy_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", outs(), 5'b1_0_111);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", outs(), 5'b1_0_111);
    mon_on = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5]);
      chk($sformatf("vector %0d (R2-R7 flow, see table tag)", i), outs(), VEC[i][4:0]);
    end

    // R8: withdraw during drain
    ack_low_cnt = 0;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk("R8 drain entered", outs(), 5'b1_1_111);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk("R8 back to idle after drain withdraw", outs(), 5'b1_0_111);
    step(1'b1, 1'b0);
    chk("R8 ack stayed high (drain)", {4'b0, ack_low_cnt == 0}, 5'b00001);

    // R8: one-cycle request pulse
    ack_low_cnt = 0;
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R8 pulse floated", outs(), 5'b1_1_000);
    step(1'b1, 1'b0);
    chk("R8 pulse back to idle", outs(), 5'b1_0_111);
    chk("R8 ack stayed high (pulse)", {4'b0, ack_low_cnt == 0}, 5'b00001);

    // R1: asynchronous reset while granted
    step(1'b0, 1'b0);
    repeat (4) step(1'b0, 1'b0);
    chk("R3 granted before reset", outs(), 5'b0_1_000);
    mon_on = 1'b0;
    #1 rst_ni = 1'b0;
    #1 chk("R1 async reset while granted", outs(), 5'b1_0_111);
    hold_req_ni = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset release", outs(), 5'b1_0_111);

    chk("R9 no overlap of ack and drive", {4'b0, overlap_cnt == 0}, 5'b00001);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule